// File: doc/BRIEF.md
# I2C master byte transmitter

This block drives a two-wire bus as its single master, transmitting only. A host (or a DMA engine) asks for a start, a repeated start or a stop, and hands over one byte at a time. Each byte goes out MSB first. The block then releases the data line for a ninth clock and latches the slave's acknowledge level. The clock line's half period is a programmable number of system clocks. Both lines are open drain: each output is a pull-low enable, and the data line has its own sampled input.

The block has three one-cycle interrupt pulses. `txi_o` and `rxi_o` report the end of a frame. `sti_o` reports that a start, repeated start or stop has been generated. With `int_mode_i` high, every finished frame pulses `txi_o`. With it low, an acknowledged frame pulses `rxi_o`, so that a DMA engine can feed the next byte, and a refused frame pulses `txi_o`, so that software can handle the error. After a frame the block holds the clock low and waits for the host, including after a NACK.

The first frame after any start has its LSB forced low, which is the write direction bit. A 10-bit addressing input stretches the address phase to two frames.

Top module: `i2c_tx_master`

## Requirements
- R1: On `start_i` while idle, the block holds SDA released with SCL released for one half period, then pulls SDA low with SCL released for one half period. It then pulls SCL low and pulses `sti_o`, which is seen 2·H+1 cycles after the request cycle, where H is the half period.
- R2: The half period H is `div_i` system clocks, with values below 4 taken as 4. A frame is 9 SCL periods: 8 data bits, MSB first, then a ninth clock with SDA released. SDA changes while SCL is released only for start and stop conditions.
- R3: The first frame after a start or repeated start is sent with bit 0 driven low (write). Later frames are sent unchanged.
- R4: `addr_phase_o` is 1 from the end of a start until the address frames have been accepted. That is one frame with `addr10_i`=0 and two frames with `addr10_i`=1. It is then 0.
- R5: With `int_mode_i`=1, every frame ends with a one-cycle `txi_o` pulse 18·H+1 cycles after the write cycle, that is after the ninth clock has fallen, and `rxi_o` stays 0.
- R6: With `int_mode_i`=0, a frame whose ninth-clock SDA level is low (ACK) pulses `rxi_o`. A frame whose level is high (NACK) pulses `txi_o`.
- R7: `ack_flag_o` holds the SDA level sampled in the last ninth clock: 0 for ACK, 1 for NACK.
- R8: After a NACK the block does not stop the bus. SCL stays pulled low and no stop is generated until the host issues a command.
- R9: On `stop_i` while holding the bus, SDA is pulled low during an SCL low phase. SCL is then released, SDA is released one half period later, and `sti_o` pulses 3·H+1 cycles after the request cycle, leaving both lines released.
- R10: On `start_i` while holding the bus, SDA is released during an SCL low phase and a new start condition follows. `sti_o` pulses 3·H+1 cycles after the request cycle.
- R11: A `wr_i` while idle, during a frame or condition, or in the same cycle as `start_i` or `stop_i`, is ignored and sets the sticky `wr_err_o`, which only reset clears.
- R12: A `wr_i` issued in the cycle `txi_o` or `rxi_o` is high is accepted and starts the next frame without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | SCL half period in system clocks (minimum 4) |
| int_mode_i | input | 1 | 1: frame-done interrupts; 0: ACK/NACK split |
| addr10_i | input | 1 | 1: two address frames after a start |
| start_i | input | 1 | Start or repeated-start request |
| stop_i | input | 1 | Stop request |
| wr_i | input | 1 | Byte write strobe |
| wdata_i | input | DATA_W | Byte to transmit |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| txi_o | output | 1 | Frame done (or NACK in split mode) pulse |
| rxi_o | output | 1 | ACK pulse in split mode |
| sti_o | output | 1 | Start/stop generation done pulse |
| ack_flag_o | output | 1 | Last acknowledge level (0 ACK, 1 NACK) |
| addr_phase_o | output | 1 | Address frames still expected |
| wr_err_o | output | 1 | Sticky ignored-write flag |

## Verification
Two of the block's actions can fall in the same cycle: a host write and the end of a frame, and a host write and a stop or restart request.

The first case comes up whenever the bench chains bytes. It drives the next `wr_i` at the sample where the completion pulse is high. The case is judged by the next frame's exact latency, the byte decoded from the bus and a clear error flag.

For the second case the bench raises `stop_i` and `wr_i` together. It then checks that the stop still completes on schedule and that the write is refused and flagged.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ST_SU, S_ST_HD, S_HOLD, S_RS_LO,
    S_BIT_LO, S_BIT_HI, S_SP_LO, S_SP_SU, S_SP_BUF
  } seg_e;
endpackage

// File: rtl/i2c_tx_timer.sv
module i2c_tx_timer #(
  parameter int unsigned DIV_W   = 12,
  parameter int unsigned MIN_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mid_o,
  output logic             end_o
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] div_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= MIN_V;
      cnt_q <= '0;
    end else if (!run_i) begin
      div_q <= (div_i < MIN_V) ? MIN_V : div_i;
      cnt_q <= '0;
    end else if (end_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign end_o = run_i && (cnt_q == div_q - 1'b1);
  assign mid_o = run_i && (cnt_q == (div_q >> 1));

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_q); // R2
  AST_DIV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> $stable(div_q)); // R2
endmodule

// File: rtl/i2c_tx_seq.sv
module i2c_tx_seq
  import i2c_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              addr10_i,
  input  logic              sda_i,
  input  logic              mid_i,
  input  logic              end_i,
  output logic              run_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              frame_end_o,
  output logic              cond_done_o,
  output logic              nack_o,
  output logic              addr_phase_o,
  output logic              wr_err_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  seg_e              state_q, state_d;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  bit_q;
  logic              sda_q, ack_q, err_q, first_q;
  logic [1:0]        addr_left_q;
  logic              wr_take;

  assign wr_take = (state_q == S_HOLD) && wr_i && !start_i && !stop_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_ST_SU;
      S_HOLD: begin
        if (stop_i)       state_d = S_SP_LO;
        else if (start_i) state_d = S_RS_LO;
        else if (wr_i)    state_d = S_BIT_LO;
      end
      S_RS_LO:  if (end_i) state_d = S_ST_SU;
      S_ST_SU:  if (end_i) state_d = S_ST_HD;
      S_ST_HD:  if (end_i) state_d = S_HOLD;
      S_BIT_LO: if (end_i) state_d = S_BIT_HI;
      S_BIT_HI: if (end_i) state_d = (bit_q == LAST) ? S_HOLD : S_BIT_LO;
      S_SP_LO:  if (end_i) state_d = S_SP_SU;
      S_SP_SU:  if (end_i) state_d = S_SP_BUF;
      S_SP_BUF: if (end_i) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  // data line: changes at mid of SCL low, or at segment ends for conditions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_ST_SU:  if (end_i) sda_q <= 1'b1;
        S_RS_LO:  if (mid_i) sda_q <= 1'b0;
        S_BIT_LO: if (mid_i) sda_q <= (bit_q == LAST) ? 1'b0 : ~shift_q[DATA_W-1];
        S_SP_LO:  if (mid_i) sda_q <= 1'b1;
        S_SP_SU:  if (end_i) sda_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      bit_q   <= '0;
      ack_q   <= 1'b0;
    end else if (wr_take) begin
      shift_q <= first_q ? {wdata_i[DATA_W-1:1], 1'b0} : wdata_i;
      bit_q   <= '0;
    end else if (state_q == S_BIT_HI) begin
      if (mid_i && bit_q == LAST) ack_q <= sda_i;
      if (end_i) begin
        shift_q <= {shift_q[DATA_W-2:0], 1'b0};
        bit_q   <= bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q     <= 1'b0;
      addr_left_q <= 2'd0;
    end else if (state_q == S_ST_HD && end_i) begin
      first_q     <= 1'b1;
      addr_left_q <= addr10_i ? 2'd2 : 2'd1;
    end else if (state_q == S_SP_BUF && end_i) begin
      first_q     <= 1'b0;
      addr_left_q <= 2'd0;
    end else if (wr_take) begin
      first_q <= 1'b0;
      if (addr_left_q != 2'd0) addr_left_q <= addr_left_q - 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             err_q <= 1'b0;
    else if (wr_i && !wr_take) err_q <= 1'b1;
  end

  assign run_o        = (state_q != S_IDLE) && (state_q != S_HOLD);
  assign scl_oe_o     = (state_q == S_HOLD) || (state_q == S_RS_LO) ||
                        (state_q == S_BIT_LO) || (state_q == S_SP_LO);
  assign sda_oe_o     = sda_q;
  assign frame_end_o  = (state_q == S_BIT_HI) && end_i && (bit_q == LAST);
  assign cond_done_o  = end_i && ((state_q == S_ST_HD) || (state_q == S_SP_BUF));
  assign nack_o       = ack_q;
  assign addr_phase_o = addr_left_q != 2'd0;
  assign wr_err_o     = err_q;

  AST_SDA_ONLY_COND_WHEN_SCL_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_q) && !scl_oe_o) |-> (state_q == S_ST_HD || state_q == S_SP_BUF)); // R2
  AST_HOLD_UNTIL_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD && !start_i && !stop_i && !wr_i) |=> state_q == S_HOLD); // R8
  AST_BAD_WRITE_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && state_q != S_HOLD) |=> wr_err_o); // R11
endmodule

// File: rtl/i2c_tx_irq.sv
module i2c_tx_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_mode_i,
  input  logic frame_end_i,
  input  logic cond_done_i,
  input  logic nack_i,
  output logic txi_o,
  output logic rxi_o,
  output logic sti_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txi_o <= 1'b0;
      rxi_o <= 1'b0;
      sti_o <= 1'b0;
    end else begin
      txi_o <= frame_end_i && (int_mode_i || nack_i);
      rxi_o <= frame_end_i && !int_mode_i && !nack_i;
      sti_o <= cond_done_i;
    end
  end

  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({txi_o, rxi_o, sti_o})); // R5
  AST_RXI_SPLIT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxi_o |-> !$past(int_mode_i)); // R6
endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
  parameter int unsigned DIV_W   = 12,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MIN_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              int_mode_i,
  input  logic              addr10_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              txi_o,
  output logic              rxi_o,
  output logic              sti_o,
  output logic              ack_flag_o,
  output logic              addr_phase_o,
  output logic              wr_err_o
);
  logic run, mid, seg_end, frame_end, cond_done, nack;

  i2c_tx_timer #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .div_i, .mid_o(mid), .end_o(seg_end)
  );

  i2c_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .stop_i, .wr_i, .wdata_i, .addr10_i, .sda_i,
    .mid_i(mid), .end_i(seg_end), .run_o(run), .scl_oe_o, .sda_oe_o,
    .frame_end_o(frame_end), .cond_done_o(cond_done), .nack_o(nack),
    .addr_phase_o, .wr_err_o
  );

  i2c_tx_irq u_irq (
    .clk_i, .rst_ni, .int_mode_i, .frame_end_i(frame_end),
    .cond_done_i(cond_done), .nack_i(nack), .txi_o, .rxi_o, .sti_o
  );

  assign ack_flag_o = nack;
endmodule

// File: tb/i2c_tx_master_test.sv
`timescale 1ns/1ps
module i2c_tx_master_test;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [11:0] div_i = 12'd6;
  logic        int_mode_i = 1'b1, addr10_i = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic        sda_i;
  logic        scl_oe_o, sda_oe_o, txi_o, rxi_o, sti_o, ack_flag_o, addr_phase_o, wr_err_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  i2c_tx_master uut (
    .clk_i(clk), .rst_ni, .div_i, .int_mode_i, .addr10_i, .start_i, .stop_i,
    .wr_i, .wdata_i, .sda_i, .scl_oe_o, .sda_oe_o, .txi_o, .rxi_o, .sti_o,
    .ack_flag_o, .addr_phase_o, .wr_err_o
  );

  // bus model: wired lines, slave acknowledger and decoder
  logic       slave_pull = 1'b0, slave_ack = 1'b1;
  logic       scl_l, sda_l, scl_p = 1'b1, sda_p = 1'b1;
  logic [7:0] sh = 8'h00, mon_byte = 8'h00;
  int         bitc = 0, starts = 0, stops = 0;

  assign scl_l = ~scl_oe_o;
  assign sda_l = ~(sda_oe_o | slave_pull);
  assign sda_i = sda_l;

  always @(negedge clk) begin
    if (scl_l && scl_p && sda_p && !sda_l) begin starts++; bitc = 0; end
    else if (scl_l && scl_p && !sda_p && sda_l) stops++;
    if (scl_l && !scl_p) begin
      if (bitc < 8) begin
        sh = {sh[6:0], sda_l}; bitc++;
        if (bitc == 8) mon_byte = sh;
      end else if (bitc == 8) bitc = 9;
    end
    if (!scl_l && scl_p) begin
      if (bitc == 8) slave_pull = slave_ack;
      else if (bitc == 9) begin slave_pull = 1'b0; bitc = 0; end
    end
    scl_p = scl_l; sda_p = sda_l;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive request at a negedge; k = negedge count until sti_o seen
  task automatic issue(input logic st, input logic sp, input logic w, output int k);
    start_i = st; stop_i = sp; wr_i = w;
    @(negedge clk); start_i = 0; stop_i = 0; wr_i = 0; k = 1;
    while (!sti_o && k < 5000) begin @(negedge clk); k++; end
  endtask

  // write a byte; optional second write at negedge poke_at; returns at completion pulse
  task automatic send_byte(input logic [7:0] d, input logic a, input int poke_at, output int k);
    slave_ack = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0; k = 1;
    while (!(txi_o || rxi_o) && k < 5000) begin
      @(negedge clk); k++;
      if (k == poke_at) begin wr_i = 1'b1; wdata_i = 8'h11; end
      else wr_i = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // {int_mode, slave_ack, data}
  localparam logic [9:0] VEC [0:7] = '{10'h33C, 10'h281, 10'h15A, 10'h0FF,
                                       10'h300, 10'h196, 10'h001, 10'h3C3};

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int k;
    int h;
    h = 6;
    do_reset();
    chk(!scl_oe_o && !sda_oe_o, "R9 reset lines released", {scl_oe_o, sda_oe_o}, 0);
    chk(!txi_o && !rxi_o && !sti_o, "R5 reset no pulses", {txi_o, rxi_o, sti_o}, 0);
    chk(!wr_err_o && !addr_phase_o && !ack_flag_o, "R11 reset flags",
        {wr_err_o, addr_phase_o, ack_flag_o}, 0);

    // R11: write while idle is ignored
    wdata_i = 8'h55; wr_i = 1'b1; @(negedge clk); wr_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(!scl_oe_o && !sda_oe_o && starts == 0, "R11 idle write no bus effect", scl_oe_o, 0);
    chk(wr_err_o, "R11 idle write flagged", wr_err_o, 1);
    do_reset();

    // R1: start
    issue(1, 0, 0, k);
    chk(k == 2*h+1, "R1 start latency", k, 2*h+1);
    chk(starts == 1 && scl_oe_o, "R1 start on bus, SCL held", starts, 1);
    chk(addr_phase_o, "R4 address phase after start (7-bit)", addr_phase_o, 1);

    // R3/R5: address frame, write bit forced low
    send_byte(8'hA5, 1'b1, 0, k);
    chk(k == 18*h+1, "R5 txi after full frame", k, 18*h+1);
    chk(txi_o && !rxi_o, "R5 frame mode pulse", {txi_o, rxi_o}, 2);
    chk(mon_byte == 8'hA4, "R3 write bit low", mon_byte, 8'hA4);
    chk(!addr_phase_o, "R4 address phase over (7-bit)", addr_phase_o, 0);

    // table walk; back-to-back entries exercise R12
    for (int i = 0; i < 8; i++) begin
      logic m, a;
      logic [7:0] d;
      {m, a, d} = VEC[i];
      int_mode_i = m;
      send_byte(d, a, 0, k);
      chk(k == 18*h+1, "R2 frame length", k, 18*h+1);
      chk(mon_byte == d, "R2 byte MSB first", mon_byte, d);
      chk(txi_o == (m || !a) && rxi_o == (!m && a), m ? "R5 frame mode" : "R6 split mode",
          {txi_o, rxi_o}, {(m || !a), (!m && a)});
      chk(ack_flag_o == !a, "R7 ack flag", ack_flag_o, !a);
      if (!a) begin
        repeat (40) @(negedge clk);
        chk(scl_oe_o && stops == 0 && !sti_o, "R8 bus held after NACK", scl_oe_o, 1);
      end
    end
    chk(!wr_err_o, "R12 write in completion cycle accepted", wr_err_o, 0);

    // R10 restart with two address frames
    int_mode_i = 1'b1; addr10_i = 1'b1;
    issue(1, 0, 0, k);
    chk(k == 3*h+1, "R10 restart latency", k, 3*h+1);
    chk(starts == 2 && stops == 0, "R10 repeated start seen", starts, 2);
    send_byte(8'hF1, 1'b1, 0, k);
    chk(mon_byte == 8'hF0, "R3 first frame after restart", mon_byte, 8'hF0);
    chk(addr_phase_o, "R4 second address frame pending", addr_phase_o, 1);
    send_byte(8'h37, 1'b1, 0, k);
    chk(mon_byte == 8'h37, "R3 second address frame unchanged", mon_byte, 8'h37);
    chk(!addr_phase_o, "R4 address phase over (10-bit)", addr_phase_o, 0);

    // R9 stop, with R11 write in same cycle
    issue(0, 1, 1, k);
    chk(k == 3*h+1, "R9 stop latency", k, 3*h+1);
    chk(stops == 1 && !scl_oe_o && !sda_oe_o, "R9 stop on bus, lines released", stops, 1);
    chk(wr_err_o, "R11 write with stop refused", wr_err_o, 1);

    // R11: write during a frame
    do_reset();
    addr10_i = 1'b0;
    issue(1, 0, 0, k);
    send_byte(8'h20, 1'b1, 0, k);
    send_byte(8'h6E, 1'b1, 20, k);
    chk(mon_byte == 8'h6E && k == 18*h+1, "R11 mid-frame write no effect", mon_byte, 8'h6E);
    chk(wr_err_o, "R11 mid-frame write flagged", wr_err_o, 1);

    // R2 divider clamp
    do_reset();
    div_i = 12'd2;
    issue(1, 0, 0, k);
    chk(k == 2*4+1, "R2 divider below 4 clamped", k, 9);

    summary();
    $finish;
  end
endmodule